// File: doc/BRIEF.md
# Load-Use Interlock and Forwarding Unit

This block sits at the issue point of a core with two register files. Scalar loads have a short pipe. Vector loads have a much longer one. Each cycle the issue stage presents one bundle, made of an optional memory access and up to `NSRC` source operands. The unit keeps a record of in-flight loads for each destination register, and from that record it decides three things for the bundle:

- whether the bundle must wait,
- which of its vector sources take their value from the forwarding path,
- whether an exclusive access is still waiting for its synchronisation stage.

Scalar and vector records are kept apart, so register 5 of one file never matches register 5 of the other.

Scalar results arrive at stage 5, but a scalar consumer reads its operands at stage 4. A dependent consumer issued directly behind a scalar load therefore loses exactly one cycle. A vector load uses its memory port at stage 9 and writes its result at stage 10. The following bundle picks that result up from the forwarding path with no bubble.

A stalled bundle is held and re-presented by the issue stage, and the records keep ageing while it waits. A flush wipes every record.

Top module: `ldu_hazard_unit`

## Requirements
- R1: While reset is asserted and directly after it, `stall`, every `byp_fwd` bit and `barrier_busy` are 0.
- R2: A scalar load that issues in cycle t makes a valid scalar source naming the same register raise `stall` in cycle t+1 only. The stall lasts exactly one cycle (result stage 5 minus read stage 4).
- R3: A valid scalar source naming that register in cycle t+2 or later sees no stall.
- R4: A vector load that issues in cycle t sets `byp_fwd[k]` in cycle t+1 for each valid vector source k naming its register, with no stall. In cycle t+2 that bit is 0 again, because the result is then in the register file.
- R5: Scalar and vector records are separate. A scalar source never stalls on a vector load, and a vector source never forwards from a scalar load, even when the index is the same.
- R6: A source in the same bundle as a load to the same register neither stalls nor forwards from that load. It reads the old value. The load still counts for the bundles that follow.
- R7: A load in a stalled bundle is not recorded. The earlier records keep ageing during the stall, so the re-presented bundle issues and records its load then.
- R8: An exclusive access (load or store) that issues in cycle t drives `barrier_busy` high in cycles t+1 to t+6 and low in cycle t+7. This ends one stage after its stage-5 data.
- R9: Stores, whether scalar or vector, create no record. A later source naming the store's `mem_dst` value neither stalls nor forwards.
- R10: `flush` clears every record and the barrier, so in the next cycle nothing stalls, forwards or is busy. An access presented in the flush cycle is discarded.
- R11: A source with `src_valid[k]` = 0 never causes a stall or a forward, whatever its register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight records and the barrier |
| mem_valid | input | 1 | The bundle carries a memory access |
| mem_store | input | 1 | 1 = store (no destination record), 0 = load |
| mem_vec | input | 1 | 1 = vector register file, 0 = scalar |
| mem_excl | input | 1 | Exclusive access; starts the sync barrier |
| mem_dst | input | IDX_W (5) | Destination register index of a load |
| src_valid | input | NSRC (4) | Source k is used by the bundle |
| src_vec | input | NSRC (4) | Source k reads the vector file (1) or the scalar file (0) |
| src_reg | input | NSRC*IDX_W (20) | Source k register index in bits [k*IDX_W +: IDX_W] |
| stall | output | 1 | Hold the presented bundle this cycle |
| byp_fwd | output | NSRC (4) | Source k takes the vector-load forwarding path |
| barrier_busy | output | 1 | An exclusive access has not yet reached its sync stage |

## Verification
The bench goes after the timing edges that sit next to each other:

- **Consumer one cycle behind a scalar load.** It must stall exactly once. A wrong countdown stalls twice or not at all.
- **Consumer two cycles behind a scalar load.** It must not stall. A design that holds the record too long adds a spurious bubble here.
- **Same-bundle dependency.** The source must neither stall nor forward. A design that checks the incoming load against its own bundle's sources would forward stale data or deadlock.
- **Stalled bundle carrying a new load.** If that load were recorded while the bundle waits, it would stall its own re-issue.
- **Cross-file index match.** A design that shares one record table between the two files would stall on a register of the other file.
- **Barrier window.** The edge cycles at t+6 and t+7 are checked, which catches an off-by-one in the counter.
- **Flush cycle.** An access presented with the flush must be dropped. A design that gives new issue priority over flush would leave a live record behind.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

   // Register file selected by an access or a source operand
   typedef enum logic {
      RF_SCALAR = 1'b0,
      RF_VECTOR = 1'b1
   } ldu_rf_e;

   // Decoded memory access after the issue decision
   typedef struct packed {
      logic    fire;   // the bundle issues and carries an access
      logic    store;  // store: no destination record
      ldu_rf_e rf;     // destination register file
      logic    excl;   // exclusive access
   } ldu_op_t;

endpackage

// File: rtl/ldu_scoreboard.sv
// Per-register pending records for one register file.
module ldu_scoreboard #(
   parameter int NREG  = 16,
   parameter int IDX_W = 5,
   parameter int HOLD  = 1   // cycles a record stays pending after issue
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   output logic [NREG-1:0]  pend
);
   localparam int CNT_W = $clog2(HOLD + 1);

   if (NREG > (1 << IDX_W)) begin : g_bad_idx
      $error("ldu_scoreboard: NREG does not fit in IDX_W bits");
   end
   if (HOLD < 1) begin : g_bad_hold
      $error("ldu_scoreboard: HOLD must be at least 1");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_ent
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);
      logic hit;
      assign hit = set_en && (set_idx == MY_IDX);

      if (HOLD == 1) begin : g_flag
         // single-cycle window: one flop per register
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (flush) flag_q <= 1'b0;
            else            flag_q <= hit;
         end
         assign pend[r] = flag_q;
      end else begin : g_cnt
         // multi-cycle window: down-counter per register
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (flush)          cnt_q <= '0;
            else if (hit)            cnt_q <= CNT_W'(HOLD);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign pend[r] = (cnt_q != '0);
      end
   end

endmodule

// File: rtl/ldu_lookup.sv
// Tests one source index against a pending vector.
module ldu_lookup #(
   parameter int NREG  = 16,
   parameter int IDX_W = 5
) (
   input  logic [NREG-1:0]  pend,
   input  logic [IDX_W-1:0] idx,
   output logic             hit
);
   always_comb begin
      hit = 1'b0;
      for (int r = 0; r < NREG; r++) begin
         if (idx == IDX_W'(r)) hit = pend[r];
      end
   end
endmodule

// File: rtl/ldu_barrier.sv
// Busy window of an exclusive access until its sync stage.
module ldu_barrier #(
   parameter int CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(CYC + 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("ldu_barrier: CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (flush)        cnt_q <= '0;
      else if (start)        cnt_q <= CNT_W'(CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end
   assign busy = (cnt_q != '0);
endmodule

// File: rtl/ldu_hazard_unit.sv
module ldu_hazard_unit
   import ldu_pkg::*;
#(
   parameter int NSRC         = 4,
   parameter int NREG_S       = 16,
   parameter int NREG_V       = 32,
   parameter int SC_RD_STG    = 4,   // scalar operand read stage
   parameter int SC_RES_STG   = 5,   // scalar load result stage
   parameter int VEC_PORT_STG = 9,   // vector memory port stage
   parameter int VEC_RES_STG  = 10,  // vector result stage
   parameter int SYNC_STG     = 6,   // exclusive sync barrier stage
   localparam int IDX_W = $clog2((NREG_S > NREG_V) ? NREG_S : NREG_V)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  mem_valid,
   input  logic                  mem_store,
   input  logic                  mem_vec,
   input  logic                  mem_excl,
   input  logic [IDX_W-1:0]      mem_dst,
   input  logic [NSRC-1:0]       src_valid,
   input  logic [NSRC-1:0]       src_vec,
   input  logic [NSRC*IDX_W-1:0] src_reg,
   output logic                  stall,
   output logic [NSRC-1:0]       byp_fwd,
   output logic                  barrier_busy
);
   localparam int SC_HOLD  = SC_RES_STG - SC_RD_STG;
   localparam int VEC_HOLD = VEC_RES_STG - VEC_PORT_STG;
   localparam int BAR_CYC  = SYNC_STG;

   if (SC_HOLD < 1) begin : g_bad_sc
      $error("ldu_hazard_unit: scalar read stage must precede result stage");
   end
   if (VEC_HOLD < 1) begin : g_bad_vec
      $error("ldu_hazard_unit: vector port stage must precede result stage");
   end
   if (SYNC_STG <= SC_RES_STG) begin : g_bad_sync
      $error("ldu_hazard_unit: sync stage must follow scalar result stage");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("ldu_hazard_unit: NSRC must be at least 1");
   end

   logic [NREG_S-1:0] pend_s;
   logic [NREG_V-1:0] pend_v;
   logic [NSRC-1:0]   hit_s, hit_v;
   ldu_op_t           op;

   // Per-source lookups in both files
   for (genvar k = 0; k < NSRC; k++) begin : g_src
      ldu_lookup #(.NREG(NREG_S), .IDX_W(IDX_W)) u_lk_s (
         .pend (pend_s),
         .idx  (src_reg[k*IDX_W +: IDX_W]),
         .hit  (hit_s[k])
      );
      ldu_lookup #(.NREG(NREG_V), .IDX_W(IDX_W)) u_lk_v (
         .pend (pend_v),
         .idx  (src_reg[k*IDX_W +: IDX_W]),
         .hit  (hit_v[k])
      );
   end

   // Scalar hit interlocks; vector hit selects the forwarding path
   assign stall   = |(src_valid & ~src_vec & hit_s);
   assign byp_fwd = src_valid & src_vec & hit_v;

   // Issue decision: a held bundle and a flushed one record nothing
   always_comb begin
      op.fire  = mem_valid && !stall && !flush;
      op.store = mem_store;
      op.rf    = mem_vec ? RF_VECTOR : RF_SCALAR;
      op.excl  = mem_excl;
   end

   ldu_scoreboard #(.NREG(NREG_S), .IDX_W(IDX_W), .HOLD(SC_HOLD)) u_sb_s (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .set_en  (op.fire && !op.store && (op.rf == RF_SCALAR)),
      .set_idx (mem_dst),
      .pend    (pend_s)
   );

   ldu_scoreboard #(.NREG(NREG_V), .IDX_W(IDX_W), .HOLD(VEC_HOLD)) u_sb_v (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .set_en  (op.fire && !op.store && (op.rf == RF_VECTOR)),
      .set_idx (mem_dst),
      .pend    (pend_v)
   );

   ldu_barrier #(.CYC(BAR_CYC)) u_bar (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .start (op.fire && op.excl),
      .busy  (barrier_busy)
   );

endmodule

// File: rtl/ldu_hazard_chk.sv
module ldu_hazard_chk #(
   parameter int NSRC         = 4,
   parameter int NREG_S       = 16,
   parameter int NREG_V       = 32,
   parameter int SC_RD_STG    = 4,
   parameter int SC_RES_STG   = 5,
   parameter int VEC_PORT_STG = 9,
   parameter int VEC_RES_STG  = 10,
   parameter int SYNC_STG     = 6,
   localparam int IDX_W = $clog2((NREG_S > NREG_V) ? NREG_S : NREG_V)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  flush,
   input logic                  mem_valid,
   input logic                  mem_store,
   input logic                  mem_vec,
   input logic                  mem_excl,
   input logic [IDX_W-1:0]      mem_dst,
   input logic [NSRC-1:0]       src_valid,
   input logic [NSRC-1:0]       src_vec,
   input logic [NSRC*IDX_W-1:0] src_reg,
   input logic                  stall,
   input logic [NSRC-1:0]       byp_fwd,
   input logic                  barrier_busy
);
   localparam int SC_HOLD  = SC_RES_STG - SC_RD_STG;
   localparam int VEC_HOLD = VEC_RES_STG - VEC_PORT_STG;
   localparam int W        = 8;

   logic fire, fire_vld, fire_x;
   assign fire     = mem_valid && !stall && !flush;
   assign fire_vld = fire && !mem_store && mem_vec;
   assign fire_x   = fire && mem_excl;

   logic [W-1:0] stall_run, since_v, since_x;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_run <= '0;
         since_v   <= W'(VEC_HOLD);
         since_x   <= W'(SYNC_STG);
      end else begin
         stall_run <= stall ? stall_run + 1'b1 : '0;
         if (flush)                   since_v <= W'(VEC_HOLD);
         else if (fire_vld)           since_v <= '0;
         else if (since_v < W'(VEC_HOLD)) since_v <= since_v + 1'b1;
         if (flush)                   since_x <= W'(SYNC_STG);
         else if (fire_x)             since_x <= '0;
         else if (since_x < W'(SYNC_STG)) since_x <= since_x + 1'b1;
      end
   end

   // R2
   stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (stall_run < W'(SC_HOLD)));

   // R5
   stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> |(src_valid & ~src_vec));

   // R4
   byp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|byp_fwd) |-> (since_v < W'(VEC_HOLD)));

   // R8
   bar_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      barrier_busy |-> (since_x < W'(SYNC_STG)));

   // R8
   bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_x < W'(SYNC_STG)) |-> barrier_busy);

   // R10
   flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!barrier_busy && !stall && (byp_fwd == '0)));

endmodule

bind ldu_hazard_unit ldu_hazard_chk #(
   .NSRC(NSRC), .NREG_S(NREG_S), .NREG_V(NREG_V),
   .SC_RD_STG(SC_RD_STG), .SC_RES_STG(SC_RES_STG),
   .VEC_PORT_STG(VEC_PORT_STG), .VEC_RES_STG(VEC_RES_STG),
   .SYNC_STG(SYNC_STG)
) u_chk (.*);

// File: tb/ldu_hazard_unit_bench.sv
`timescale 1ns/1ps
module ldu_hazard_unit_bench;
   localparam int NSRC = 4;
   localparam int IDX_W = 5;
   localparam int NS = 16;
   localparam int NV = 32;

   logic clk = 1'b0;
   logic rst_n, flush, mem_valid, mem_store, mem_vec, mem_excl;
   logic [IDX_W-1:0] mem_dst;
   logic [NSRC-1:0] src_valid, src_vec;
   logic [NSRC*IDX_W-1:0] src_reg;
   logic stall, barrier_busy;
   logic [NSRC-1:0] byp_fwd;

   always #2.5 clk = ~clk;

   ldu_hazard_unit u_ldu_hazard_unit (.*);

   int n_cmp = 0, n_bad = 0;
   int sc[NS];
   int vc[NV];
   int bar;
   logic exp_stall;
   logic [NSRC-1:0] exp_byp;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic idle();
      flush = 0; mem_valid = 0; mem_store = 0; mem_vec = 0; mem_excl = 0; mem_dst = '0;
      src_valid = '0; src_vec = '0; src_reg = '0;
   endtask

   task automatic mem(input logic st, input logic v, input logic x, input int d);
      mem_valid = 1; mem_store = st; mem_vec = v; mem_excl = x; mem_dst = IDX_W'(d);
   endtask

   task automatic src(input int k, input logic v, input int r);
      src_valid[k] = 1'b1; src_vec[k] = v; src_reg[k*IDX_W +: IDX_W] = IDX_W'(r);
   endtask

   // Reference expectation from the model state and current inputs
   task automatic expect_now();
      exp_stall = 1'b0;
      exp_byp = '0;
      for (int k = 0; k < NSRC; k++) begin
         int r;
         r = int'(src_reg[k*IDX_W +: IDX_W]);
         if (src_valid[k] && !src_vec[k] && r < NS && sc[r] > 0) exp_stall = 1'b1;
         if (src_valid[k] && src_vec[k] && vc[r] > 0) exp_byp[k] = 1'b1;
      end
   endtask

   // One clock: compare, then advance the model at the edge
   task automatic cyc(input string tag);
      #1;
      expect_now();
      chk(tag, "stall", int'(stall), int'(exp_stall));
      chk(tag, "byp_fwd", int'(byp_fwd), int'(exp_byp));
      chk(tag, "barrier_busy", int'(barrier_busy), int'(bar > 0));
      @(posedge clk);
      for (int i = 0; i < NS; i++) if (sc[i] > 0) sc[i]--;
      for (int i = 0; i < NV; i++) if (vc[i] > 0) vc[i]--;
      if (bar > 0) bar--;
      if (flush) begin
         for (int i = 0; i < NS; i++) sc[i] = 0;
         for (int i = 0; i < NV; i++) vc[i] = 0;
         bar = 0;
      end else if (mem_valid && !exp_stall) begin
         if (!mem_store) begin
            if (mem_vec) vc[int'(mem_dst)] = 1;
            else if (int'(mem_dst) < NS) sc[int'(mem_dst)] = 1;
         end
         if (mem_excl) bar = 6;
      end
      @(negedge clk);
      idle();
   endtask

   logic done = 1'b0;
   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NS; i++) sc[i] = 0;
      for (int i = 0; i < NV; i++) vc[i] = 0;
      bar = 0;
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet in reset even with a source presented
      src(0, 0, 3); src(1, 1, 3);
      #1;
      chk("R1", "stall", int'(stall), 0);
      chk("R1", "byp_fwd", int'(byp_fwd), 0);
      chk("R1", "barrier_busy", int'(barrier_busy), 0);
      idle();
      rst_n = 1;
      cyc("R1");

      // R2: scalar load then dependent consumer: one bubble
      mem(0, 0, 0, 3);           cyc("R2");
      src(0, 0, 3);              cyc("R2");
      src(0, 0, 3);              cyc("R2");

      // R3: consumer two cycles later
      mem(0, 0, 0, 4);           cyc("R3");
      cyc("R3");
      src(2, 0, 4);              cyc("R3");

      // R4: vector load forwards to the next bundle only
      mem(0, 1, 0, 7);           cyc("R4");
      src(1, 1, 7); src(3, 1, 7); cyc("R4");
      src(1, 1, 7);              cyc("R4");

      // R5: files are separate
      mem(0, 1, 0, 2);           cyc("R5");
      src(0, 0, 2);              cyc("R5");
      mem(0, 0, 0, 9);           cyc("R5");
      src(0, 1, 9);              cyc("R5");

      // R6: same-bundle dependency reads the old value
      mem(0, 0, 0, 6); src(0, 0, 6); cyc("R6");
      src(1, 0, 6);              cyc("R6");
      mem(0, 1, 0, 8); src(2, 1, 8); cyc("R6");
      src(2, 1, 8);              cyc("R6");

      // R7: load inside a stalled bundle is recorded only on re-issue
      mem(0, 0, 0, 1);           cyc("R7");
      mem(0, 0, 0, 11); src(0, 0, 1); cyc("R7");
      mem(0, 0, 0, 11); src(0, 0, 1); cyc("R7");
      src(0, 0, 11);             cyc("R7");
      src(0, 0, 11);             cyc("R7");

      // R8: exclusive barrier window t+1..t+6
      mem(0, 0, 1, 12);          cyc("R8");
      for (int i = 0; i < 7; i++) cyc("R8");
      mem(1, 1, 1, 0);           cyc("R8");
      for (int i = 0; i < 7; i++) cyc("R8");

      // R9: stores record nothing
      mem(1, 0, 0, 13);          cyc("R9");
      src(0, 0, 13);             cyc("R9");
      mem(1, 1, 0, 13);          cyc("R9");
      src(0, 1, 13);             cyc("R9");

      // R10: flush clears barrier, drops the flush-cycle access
      mem(0, 0, 1, 15);          cyc("R10");
      flush = 1; mem(0, 1, 1, 20); cyc("R10");
      src(0, 1, 20); src(1, 0, 15); cyc("R10");
      cyc("R10");

      // R11: invalid sources are ignored
      mem(0, 0, 0, 5);           cyc("R11");
      src_reg[0 +: IDX_W] = 5'd5; src_vec = '0; cyc("R11");
      mem(0, 1, 0, 5);           cyc("R11");
      src_reg[IDX_W +: IDX_W] = 5'd5; src_vec = 4'b0010; cyc("R11");

      // Mixed traffic against the model
      for (int n = 0; n < 600; n++) begin
         if ($urandom_range(0, 1) == 1)
            mem(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 7) == 0), int'($urandom_range(0, 7)));
         for (int k = 0; k < NSRC; k++)
            if ($urandom_range(0, 1) == 1)
               src(k, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
         flush = ($urandom_range(0, 19) == 0);
         cyc("R2");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule